// File: doc/BRIEF.md
# Effective Address Calculation Unit

This unit turns an addressing mode, a register number and an operand size into either a 32-bit operand address or a ready-to-use operand value. It draws on a single combinational register-file read port and on a stream of 16-bit extension words. Each extension word arrives with the address it was fetched from. A `start` pulse in the idle state begins an operation. Modes that need no extension word finish on the next clock. The other modes wait for one or two words, taking each one with `ext_take`.

At completion, `done` pulses for one cycle, and `value` and `needs_fetch` are valid in that cycle. `needs_fetch` is high when `value` is a memory address that still has to be read. For the post-increment and pre-decrement modes, the unit also presents the updated address register on a write-back port in the same cycle. The caller commits that write-back to its register file.

Top module: `ea_unit`

## Requirements
- R1: Modes 0 (data register), 1 (address register) and 2 (quick, `value` = `quick_val`) return the operand itself: the data register is register-file entry `reg_num`, the address register is entry 8+`reg_num`, and `needs_fetch` is 0. Every memory mode (4..12) sets `needs_fetch` to 1.
- R2: Mode 3 (immediate) returns its operand with `needs_fetch` = 0. For size 0 (byte) it zero-extends bits 7:0 of one word. For size 1 (word) it zero-extends one word. For size 2 (long) it takes two words, the first one being bits 31:16.
- R3: Mode 9 (absolute short) sign-extends one word to 32 bits. Mode 10 (absolute long) joins two words, the first one being the high half.
- R4: Mode 5 (post-increment) returns the old An and writes back An+step. The step is 1, 2 or 4 for byte, word or long.
- R5: Mode 6 (pre-decrement) returns An−step and writes back that same value.
- R6: For byte size on register 7, the step of modes 5 and 6 is 2 instead of 1.
- R7: Mode 7 adds the sign-extended extension word to An.
- R8: Modes 11 and 12 use `ext_addr` of their extension word as the base, in place of An.
- R9: Modes 8 and 12 read an index word. Bits 7:0 are a signed displacement, bits 14:12 are the register number, and bit 15 selects an address register (1) or a data register (0). The result is base + displacement + index.
- R10: Bit 11 of the index word set adds the whole 32-bit index register. Bit 11 clear adds its sign-extended low 16 bits.
- R11: After reset, `busy`, `done`, `wb_en` and `ext_take` are 0. `ext_take` is high only while the unit is waiting for a word and `ext_valid` is high. A `start` while busy has no effect. `done` is registered on the clock edge that starts a no-word mode or takes the last word.
- R12: Mode 4 (register indirect) returns An with `needs_fetch` = 1. No write-back happens in modes other than 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (used only when idle) |
| mode | input | 4 | Addressing mode code |
| reg_num | input | 3 | Register number of the operand |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| quick_val | input | 32 | Operand value for quick mode |
| rf_sel | output | 4 | Register-file read select (0-7 data, 8-15 address) |
| rf_data | input | 32 | Register-file read data |
| ext_valid | input | 1 | Extension word available |
| ext_word | input | 16 | Extension word |
| ext_addr | input | 32 | Address of the extension word |
| ext_take | output | 1 | Extension word consumed this cycle |
| busy | output | 1 | Waiting for extension words |
| done | output | 1 | Result valid this cycle |
| value | output | 32 | Address or operand |
| needs_fetch | output | 1 | `value` is a memory address |
| wb_en | output | 1 | Address-register write-back valid |
| wb_reg | output | 3 | Address register to write |
| wb_data | output | 32 | Updated address register |

## Verification
The hardest case to reach is a `start` arriving while the unit is stalled on a missing extension word. The stall matters because the register-file port is shared between the base read and the index read. The bench starts a displacement operation and then holds `ext_valid` low for several cycles. During that gap it pulses `start` with a data-register mode, which would finish at once if it were accepted. It checks that `done` stays low and that the final address still uses the first base register. The index tests put a negative value in the low half of the index register, so the 16-bit and 32-bit index forms give clearly different sums.

// File: rtl/ea_unit.sv
module ea_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [2:0]  reg_num,
  input  logic [1:0]  size,
  input  logic [31:0] quick_val,
  output logic [3:0]  rf_sel,
  input  logic [31:0] rf_data,
  input  logic        ext_valid,
  input  logic [15:0] ext_word,
  input  logic [31:0] ext_addr,
  output logic        ext_take,
  output logic        busy,
  output logic        done,
  output logic [31:0] value,
  output logic        needs_fetch,
  output logic        wb_en,
  output logic [2:0]  wb_reg,
  output logic [31:0] wb_data
);
  localparam logic [3:0] M_DREG = 4'd0, M_AREG = 4'd1, M_QUICK = 4'd2, M_IMM = 4'd3,
                         M_IND = 4'd4, M_POST = 4'd5, M_PRE = 4'd6, M_DISP = 4'd7,
                         M_INDEX = 4'd8, M_ABSW = 4'd9, M_ABSL = 4'd10,
                         M_PCDISP = 4'd11, M_PCINDEX = 4'd12;

  typedef enum logic [1:0] {S_IDLE, S_W1, S_W2} state_t;
  state_t state;

  logic [3:0]  m_mode;
  logic [2:0]  m_reg;
  logic [1:0]  m_size;
  logic [31:0] base;
  logic [15:0] hi;

  function automatic logic [31:0] step_of(input logic [2:0] r, input logic [1:0] s);
    if (s == 2'd0) return (r == 3'd7) ? 32'd2 : 32'd1;
    else if (s == 2'd1) return 32'd2;
    else return 32'd4;
  endfunction

  assign busy     = (state != S_IDLE);
  assign ext_take = busy && ext_valid;
  assign rf_sel   = (state == S_IDLE) ? {(mode != M_DREG), reg_num} : ext_word[15:12];

  logic [31:0] sext_w, disp8, index_v, step_in;
  assign sext_w  = {{16{ext_word[15]}}, ext_word};
  assign disp8   = {{24{ext_word[7]}}, ext_word[7:0]};
  assign index_v = ext_word[11] ? rf_data : {{16{rf_data[15]}}, rf_data[15:0]};
  assign step_in = step_of(reg_num, size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done <= 1'b0;
      value <= '0;
      needs_fetch <= 1'b0;
      wb_en <= 1'b0;
      wb_reg <= '0;
      wb_data <= '0;
      m_mode <= '0;
      m_reg <= '0;
      m_size <= '0;
      base <= '0;
      hi <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          m_mode <= mode;
          m_reg  <= reg_num;
          m_size <= size;
          base   <= rf_data;
          wb_reg <= reg_num;
          case (mode)
            M_DREG, M_AREG: begin
              value <= rf_data; needs_fetch <= 1'b0; done <= 1'b1;
            end
            M_QUICK: begin
              value <= quick_val; needs_fetch <= 1'b0; done <= 1'b1;
            end
            M_IND: begin
              value <= rf_data; needs_fetch <= 1'b1; done <= 1'b1;
            end
            M_POST: begin
              value <= rf_data; needs_fetch <= 1'b1; done <= 1'b1;
              wb_en <= 1'b1; wb_data <= rf_data + step_in;
            end
            M_PRE: begin
              value <= rf_data - step_in; needs_fetch <= 1'b1; done <= 1'b1;
              wb_en <= 1'b1; wb_data <= rf_data - step_in;
            end
            M_IMM, M_DISP, M_INDEX, M_ABSW, M_ABSL, M_PCDISP, M_PCINDEX:
              state <= S_W1;
            default: begin
              value <= '0; needs_fetch <= 1'b0; done <= 1'b1;
            end
          endcase
        end
        S_W1: if (ext_valid) begin
          needs_fetch <= (m_mode != M_IMM);
          case (m_mode)
            M_IMM: begin
              if (m_size == 2'd0) begin
                value <= {24'd0, ext_word[7:0]}; done <= 1'b1; state <= S_IDLE;
              end else if (m_size == 2'd1) begin
                value <= {16'd0, ext_word}; done <= 1'b1; state <= S_IDLE;
              end else begin
                hi <= ext_word; state <= S_W2;
              end
            end
            M_ABSL: begin
              hi <= ext_word; state <= S_W2;
            end
            M_ABSW: begin
              value <= sext_w; done <= 1'b1; state <= S_IDLE;
            end
            M_DISP: begin
              value <= base + sext_w; done <= 1'b1; state <= S_IDLE;
            end
            M_PCDISP: begin
              value <= ext_addr + sext_w; done <= 1'b1; state <= S_IDLE;
            end
            M_INDEX: begin
              value <= base + disp8 + index_v; done <= 1'b1; state <= S_IDLE;
            end
            default: begin
              value <= ext_addr + disp8 + index_v; done <= 1'b1; state <= S_IDLE;
            end
          endcase
        end
        default: if (ext_valid) begin
          value <= {hi, ext_word};
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  p_post_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_mode == M_POST) |-> (wb_en && wb_data == value + step_of(m_reg, m_size)));

  p_pre_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_mode == M_PRE) |-> (wb_en && wb_data == value));

  p_value_modes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && m_mode <= M_IMM) |-> (!needs_fetch && !wb_en));

  p_wb_only_ptr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && (m_mode == M_POST || m_mode == M_PRE)));

  p_stall_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ext_valid) |=> (busy && !done && $stable(m_mode)));
endmodule

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [2:0] reg_num = '0;
  logic [1:0] size = '0;
  logic [31:0] quick_val = '0;
  logic [3:0] rf_sel;
  logic [31:0] rf_data;
  logic ext_valid = 1'b0;
  logic [15:0] ext_word = '0;
  logic [31:0] ext_addr = '0;
  logic ext_take, busy, done, needs_fetch, wb_en;
  logic [31:0] value, wb_data;
  logic [2:0] wb_reg;

  logic [31:0] rf [16];
  assign rf_data = rf[rf_sel];

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ea_unit u_ea_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_num(reg_num),
    .size(size), .quick_val(quick_val), .rf_sel(rf_sel), .rf_data(rf_data),
    .ext_valid(ext_valid), .ext_word(ext_word), .ext_addr(ext_addr),
    .ext_take(ext_take), .busy(busy), .done(done), .value(value),
    .needs_fetch(needs_fetch), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx16(input logic [15:0] w);
    return {{16{w[15]}}, w};
  endfunction

  function automatic logic [31:0] idx_sum(input logic [31:0] b, input logic [15:0] w);
    logic [31:0] r;
    r = rf[{w[15], w[14:12]}];
    if (!w[11]) r = sx16(r[15:0]);
    return b + {{24{w[7]}}, w[7:0]} + r;
  endfunction

  task automatic run_op(input logic [3:0] m, input logic [2:0] r, input logic [1:0] s,
                        input int n, input logic [15:0] w0, input logic [15:0] w1,
                        input logic [31:0] a, input string req);
    @(negedge clk);
    start = 1'b1; mode = m; reg_num = r; size = s;
    @(negedge clk);
    start = 1'b0;
    if (n > 0) begin
      ext_valid = 1'b1; ext_word = w0; ext_addr = a;
      #1 chk({req, " ext_take"}, {31'd0, ext_take}, 32'd1);
      @(negedge clk);
      if (n > 1) begin
        ext_word = w1; ext_addr = a + 32'd2;
        @(negedge clk);
      end
      ext_valid = 1'b0;
    end
    chk({req, " done"}, {31'd0, done}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R11 reset wb_en", {31'd0, wb_en}, 32'd0);
    ext_valid = 1'b1;
    #1 chk("R11 idle ext_take", {31'd0, ext_take}, 32'd0);
    ext_valid = 1'b0;
  endtask

  task automatic t_value_modes;
    run_op(4'd0, 3'd3, 2'd2, 0, 16'h0, 16'h0, 32'h0, "R1");
    chk("R1 dreg value", value, rf[3]);
    chk("R1 dreg fetch", {31'd0, needs_fetch}, 32'd0);
    run_op(4'd1, 3'd5, 2'd2, 0, 16'h0, 16'h0, 32'h0, "R1");
    chk("R1 areg value", value, rf[13]);
    chk("R1 areg fetch", {31'd0, needs_fetch}, 32'd0);
    quick_val = 32'hFFFF_FFF9;
    run_op(4'd2, 3'd0, 2'd2, 0, 16'h0, 16'h0, 32'h0, "R1");
    chk("R1 quick value", value, 32'hFFFF_FFF9);
    chk("R1 quick fetch", {31'd0, needs_fetch}, 32'd0);
  endtask

  task automatic t_immediate;
    run_op(4'd3, 3'd0, 2'd0, 1, 16'h12F3, 16'h0, 32'h100, "R2");
    chk("R2 byte imm", value, 32'h0000_00F3);
    run_op(4'd3, 3'd0, 2'd1, 1, 16'h8001, 16'h0, 32'h100, "R2");
    chk("R2 word imm", value, 32'h0000_8001);
    run_op(4'd3, 3'd0, 2'd2, 2, 16'hDEAD, 16'hBEEF, 32'h100, "R2");
    chk("R2 long imm", value, 32'hDEAD_BEEF);
    chk("R2 imm fetch", {31'd0, needs_fetch}, 32'd0);
  endtask

  task automatic t_absolute;
    run_op(4'd9, 3'd0, 2'd1, 1, 16'h8000, 16'h0, 32'h200, "R3");
    chk("R3 abs short neg", value, 32'hFFFF_8000);
    chk("R1 abs fetch", {31'd0, needs_fetch}, 32'd1);
    run_op(4'd9, 3'd0, 2'd1, 1, 16'h1234, 16'h0, 32'h200, "R3");
    chk("R3 abs short pos", value, 32'h0000_1234);
    run_op(4'd10, 3'd0, 2'd2, 2, 16'h00FE, 16'hC000, 32'h200, "R3");
    chk("R3 abs long", value, 32'h00FE_C000);
  endtask

  task automatic t_indirect;
    run_op(4'd4, 3'd2, 2'd1, 0, 16'h0, 16'h0, 32'h0, "R12");
    chk("R12 ind value", value, rf[10]);
    chk("R12 ind fetch", {31'd0, needs_fetch}, 32'd1);
    chk("R12 ind no wb", {31'd0, wb_en}, 32'd0);
  endtask

  task automatic t_postinc;
    run_op(4'd5, 3'd2, 2'd1, 0, 16'h0, 16'h0, 32'h0, "R4");
    chk("R4 post word value", value, rf[10]);
    chk("R4 post word wb", wb_data, rf[10] + 32'd2);
    chk("R4 post wb_en", {31'd0, wb_en}, 32'd1);
    chk("R4 post wb_reg", {29'd0, wb_reg}, 32'd2);
    run_op(4'd5, 3'd2, 2'd2, 0, 16'h0, 16'h0, 32'h0, "R4");
    chk("R4 post long wb", wb_data, rf[10] + 32'd4);
    run_op(4'd5, 3'd3, 2'd0, 0, 16'h0, 16'h0, 32'h0, "R4");
    chk("R4 post byte wb", wb_data, rf[11] + 32'd1);
    run_op(4'd5, 3'd7, 2'd0, 0, 16'h0, 16'h0, 32'h0, "R6");
    chk("R6 post byte a7 wb", wb_data, rf[15] + 32'd2);
  endtask

  task automatic t_predec;
    run_op(4'd6, 3'd4, 2'd2, 0, 16'h0, 16'h0, 32'h0, "R5");
    chk("R5 pre long value", value, rf[12] - 32'd4);
    chk("R5 pre long wb", wb_data, rf[12] - 32'd4);
    run_op(4'd6, 3'd4, 2'd0, 0, 16'h0, 16'h0, 32'h0, "R5");
    chk("R5 pre byte value", value, rf[12] - 32'd1);
    run_op(4'd6, 3'd7, 2'd0, 0, 16'h0, 16'h0, 32'h0, "R6");
    chk("R6 pre byte a7 value", value, rf[15] - 32'd2);
    chk("R6 pre byte a7 reg", {29'd0, wb_reg}, 32'd7);
  endtask

  task automatic t_displacement;
    run_op(4'd7, 3'd1, 2'd1, 1, 16'hFFFC, 16'h0, 32'h300, "R7");
    chk("R7 disp neg", value, rf[9] - 32'd4);
    chk("R12 disp no wb", {31'd0, wb_en}, 32'd0);
    run_op(4'd7, 3'd1, 2'd1, 1, 16'h0040, 16'h0, 32'h300, "R7");
    chk("R7 disp pos", value, rf[9] + 32'h40);
    run_op(4'd11, 3'd1, 2'd1, 1, 16'h0010, 16'h0, 32'h400, "R8");
    chk("R8 pc disp", value, 32'h0000_0410);
  endtask

  task automatic t_index;
    logic [15:0] w;
    w = 16'h50F0;
    run_op(4'd8, 3'd1, 2'd1, 1, w, 16'h0, 32'h500, "R9");
    chk("R10 index dreg word", value, idx_sum(rf[9], w));
    w = 16'h58F0;
    run_op(4'd8, 3'd1, 2'd1, 1, w, 16'h0, 32'h500, "R10");
    chk("R10 index dreg long", value, idx_sum(rf[9], w));
    w = 16'hE805;
    run_op(4'd8, 3'd1, 2'd1, 1, w, 16'h0, 32'h500, "R9");
    chk("R9 index areg", value, idx_sum(rf[9], w));
    w = 16'h5880;
    run_op(4'd12, 3'd1, 2'd1, 1, w, 16'h0, 32'h8000, "R8");
    chk("R8 pc index", value, idx_sum(32'h8000, w));
  endtask

  task automatic t_stall;
    @(negedge clk);
    start = 1'b1; mode = 4'd7; reg_num = 3'd1; size = 2'd1;
    @(negedge clk);
    mode = 4'd0; reg_num = 3'd3;
    @(negedge clk);
    chk("R11 start ignored done", {31'd0, done}, 32'd0);
    chk("R11 stall busy", {31'd0, busy}, 32'd1);
    start = 1'b0;
    @(negedge clk);
    chk("R11 stall still waiting", {31'd0, done}, 32'd0);
    ext_valid = 1'b1; ext_word = 16'h0008; ext_addr = 32'h600;
    @(negedge clk);
    ext_valid = 1'b0;
    chk("R11 stall done", {31'd0, done}, 32'd1);
    chk("R11 stall value", value, rf[9] + 32'd8);
  endtask

  initial begin
    rf[0] = 32'h0000_0010; rf[1] = 32'h1111_1111; rf[2] = 32'h2222_2222;
    rf[3] = 32'hCAFE_0003; rf[4] = 32'h4444_4444; rf[5] = 32'h0001_8004;
    rf[6] = 32'h6666_6666; rf[7] = 32'h7777_7777; rf[8] = 32'h0000_8000;
    rf[9] = 32'h0000_2000; rf[10] = 32'h0000_1000; rf[11] = 32'h0000_3001;
    rf[12] = 32'h0000_4000; rf[13] = 32'hA5A5_0005; rf[14] = 32'h0000_0100;
    rf[15] = 32'h0000_FF00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_value_modes;
    t_immediate;
    t_absolute;
    t_indirect;
    t_postinc;
    t_predec;
    t_displacement;
    t_index;
    t_stall;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule